// File: doc/BRIEF.md
# Transmit deferral and backoff controller

This block decides when a half-duplex Ethernet MAC may put a frame on the wire. It holds a pending transmit request until the carrier has been quiet for a full interframe gap. While it waits, it counts how long the frame has been deferring. If that wait becomes too long, it drops the frame, unless software has asked it to defer without limit.

When a collision hits a frame in flight, the block schedules the retry. By default it waits a random number of slot times, drawn by binary exponential backoff from an internal LFSR. A configuration bit can replace that wait with an immediate return to deferral. After sixteen collisions on one frame the block gives up.

All timing is counted in `tick_i` pulses. The MAC supplies one tick per bit time at 10 Mb/s and one tick per nibble time at 100 Mb/s. Parameters hold each time in bit times, and the block divides by four in 100 Mb/s mode.

Top module: `eth_tx_defer_ctrl`

## Requirements
- R1: With a request pending and carrier low, `tx_start_o` pulses once the block has seen IFG_BT/4 (100 Mb/s) or IFG_BT (10 Mb/s) ticks in a row without carrier (IFG_BT defaults to 96). Any cycle with carrier restarts that count.
- R2: In 10 Mb/s mode (`speed_100_i`=0) with `defer_forever_i`=0, the DEFER_LIMIT_10-th tick of carrier seen while deferring (default 24287) raises `defer_abort_o` for one cycle, and the frame is dropped without a start.
- R3: In 100 Mb/s mode the same abort happens at the DEFER_LIMIT_100-th carrier tick (default 6071). Ticks arriving every other cycle are counted one for one.
- R4: While `defer_forever_i`=1, `defer_abort_o` never rises, however long the carrier stays up. The frame starts once the carrier drops.
- R5: The deferral count adds up all carrier ticks of one attempt, including ticks on both sides of a carrier gap that was too short to start in. The count clears when a transmission starts.
- R6: With `no_backoff_i`=1, a collision sends the block straight back to deferral. With carrier low, the retry starts exactly one gap after the edge that sampled `col_i`.
- R7: With `no_backoff_i`=0, the retry after the n-th collision starts IFG + r·SLOT ticks after the collision edge. SLOT is SLOT_BT (default 512) bit times. r is an integer in [0, 2^min(n,10) − 1].
- R8: The 16th collision on one frame raises `col_abort_o` for one cycle, and the frame is not started again.
- R9: Dropping `tx_req_i` while deferring or backing off cancels the frame without any output pulse. While transmitting, a drop ends the frame, but a collision in that same cycle still takes priority.
- R10: After either abort, the block accepts no new frame until `tx_req_i` has been low for at least one cycle.
- R11: The three outputs are single-cycle pulses, and at most one of them is high in any cycle.
- R12: Reset (`rst_ni` low) forces all outputs low, returns the block to idle and clears the collision count, so the next frame again gets 16 attempts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_req_i | input | 1 | Frame pending; held high until the frame ends or an abort is seen |
| crs_i | input | 1 | Carrier sense |
| col_i | input | 1 | Collision seen during transmission |
| speed_100_i | input | 1 | 1: 100 Mb/s (tick per nibble), 0: 10 Mb/s (tick per bit) |
| tick_i | input | 1 | One pulse per bit or nibble time |
| defer_forever_i | input | 1 | 1: defer to carrier without limit |
| no_backoff_i | input | 1 | 1: retry at once after a collision |
| tx_start_o | output | 1 | Pulse: begin transmitting now |
| defer_abort_o | output | 1 | Pulse: frame dropped, deferral limit reached |
| col_abort_o | output | 1 | Pulse: frame dropped, 16 collisions |

## Verification
The properties assume the following about the inputs:
- `speed_100_i` and the two configuration bits change only while no frame is pending.
- `col_i` carries meaning only while a frame is on the wire.
- `tx_req_i` is not withdrawn in the cycle an abort appears.

The stimulus respects these assumptions. It changes every input just after the falling clock edge, and it changes speed only with the request low. The random backoff cannot be predicted from outside, so the bench checks every retry against the legal set {IFG + r·SLOT}. For those tests it keeps the carrier low and the tick continuous, so that the arithmetic stays exact.

// File: rtl/eth_dfr_pkg.sv
package eth_dfr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEFER,
    ST_XMIT,
    ST_BACKOFF,
    ST_HOLD
  } dfr_state_e;

  localparam int unsigned BITS_PER_NIBBLE = 4;
  localparam int unsigned LFSR_W          = 16;
  // x^16 + x^14 + x^13 + x^11, maximal length
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
endpackage

// File: rtl/dfr_gap_timer.sv
module dfr_gap_timer
  import eth_dfr_pkg::*;
#(
  parameter int unsigned IFG_BT   = 96,
  parameter int unsigned DLIM_10  = 24287,
  parameter int unsigned DLIM_100 = 6071
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic tick_i,
  input  logic crs_i,
  input  logic speed_100_i,
  input  logic defer_forever_i,
  output logic gap_done_o,
  output logic limit_hit_o
);
  localparam int unsigned GAP_10   = IFG_BT;
  localparam int unsigned GAP_100  = IFG_BT / BITS_PER_NIBBLE;
  localparam int unsigned DLIM_MAX = (DLIM_10 > DLIM_100) ? DLIM_10 : DLIM_100;
  localparam int unsigned DCNT_W   = $clog2(DLIM_MAX + 1);
  localparam int unsigned GAP_W    = $clog2(GAP_10 + 1);

  logic [GAP_W-1:0]  gap_q, gap_lim;
  logic [DCNT_W-1:0] dcnt_q, dlim;

  assign gap_lim = speed_100_i ? GAP_W'(GAP_100) : GAP_W'(GAP_10);
  assign dlim    = speed_100_i ? DCNT_W'(DLIM_100) : DCNT_W'(DLIM_10);

  // quiet-carrier run length; any carrier restarts it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 gap_q <= '0;
    else if (!active_i || crs_i) gap_q <= '0;
    else if (tick_i)             gap_q <= gap_q + 1'b1;
  end

  // total carrier ticks of this attempt, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        dcnt_q <= '0;
    else if (!active_i) dcnt_q <= '0;
    else if (tick_i && crs_i && (dcnt_q < DCNT_W'(DLIM_MAX)))
      dcnt_q <= dcnt_q + 1'b1;
  end

  assign gap_done_o  = active_i && tick_i && !crs_i && (gap_q >= gap_lim - GAP_W'(1));
  assign limit_hit_o = active_i && tick_i && crs_i && !defer_forever_i
                       && (dcnt_q >= dlim - DCNT_W'(1));

  AST_DCNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> dcnt_q == '0); // R5
  AST_GAP_NEEDS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crs_i |=> gap_q == '0); // R1
endmodule

// File: rtl/dfr_backoff.sv
module dfr_backoff
  import eth_dfr_pkg::*;
#(
  parameter int unsigned SLOT_BT   = 512,
  parameter int unsigned BO_CAP    = 10,
  parameter int unsigned ATT_W     = 5,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             speed_100_i,
  input  logic             load_i,
  input  logic [ATT_W-1:0] attempt_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic             zero_o,
  output logic             done_o
);
  localparam int unsigned SLOT_10  = SLOT_BT;
  localparam int unsigned SLOT_100 = SLOT_BT / BITS_PER_NIBBLE;
  localparam int unsigned SL_W     = $clog2(SLOT_10 + 1);

  logic [LFSR_W-1:0] lfsr_q;
  logic              fb;
  logic [ATT_W-1:0]  k;
  logic [BO_CAP-1:0] mask, r;
  logic [BO_CAP-1:0] slots_q;
  logic [SL_W-1:0]   slot_cnt_q, slot_lim;

  assign fb = ^(lfsr_q & LFSR_TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= LFSR_SEED;
    else         lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
  end

  assign k = (attempt_i > ATT_W'(BO_CAP)) ? ATT_W'(BO_CAP) : attempt_i;

  always_comb begin
    for (int i = 0; i < int'(BO_CAP); i++) mask[i] = (i < int'(k));
  end

  assign r        = lfsr_q[BO_CAP-1:0] & mask;
  assign zero_o   = (r == '0);
  assign slot_lim = speed_100_i ? SL_W'(SLOT_100) : SL_W'(SLOT_10);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slots_q    <= '0;
      slot_cnt_q <= '0;
    end else if (load_i) begin
      slots_q    <= r;
      slot_cnt_q <= '0;
    end else if (run_i && tick_i) begin
      if (slot_cnt_q >= slot_lim - SL_W'(1)) begin
        slot_cnt_q <= '0;
        slots_q    <= slots_q - 1'b1;
      end else begin
        slot_cnt_q <= slot_cnt_q + 1'b1;
      end
    end
  end

  assign done_o = run_i && tick_i && (slot_cnt_q >= slot_lim - SL_W'(1))
                  && (slots_q == BO_CAP'(1));

  AST_RUN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> slots_q != '0); // R7
  AST_DRAW_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (slots_q & ~$past(mask)) == '0); // R7
endmodule

// File: rtl/eth_tx_defer_ctrl.sv
module eth_tx_defer_ctrl
  import eth_dfr_pkg::*;
#(
  parameter int unsigned IFG_BT          = 96,
  parameter int unsigned SLOT_BT         = 512,
  parameter int unsigned DEFER_LIMIT_10  = 24287,
  parameter int unsigned DEFER_LIMIT_100 = 6071,
  parameter int unsigned MAX_ATTEMPTS    = 16,
  parameter int unsigned BACKOFF_CAP     = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_req_i,
  input  logic crs_i,
  input  logic col_i,
  input  logic speed_100_i,
  input  logic tick_i,
  input  logic defer_forever_i,
  input  logic no_backoff_i,
  output logic tx_start_o,
  output logic defer_abort_o,
  output logic col_abort_o
);
  localparam int unsigned ATT_W = $clog2(MAX_ATTEMPTS + 1);

  dfr_state_e       state_q, state_d;
  logic [ATT_W-1:0] att_q, att_d, att_nx;
  logic             start_d, dab_d, cab_d;
  logic             gap_done, limit_hit, bo_load, bo_zero, bo_done;

  dfr_gap_timer #(
    .IFG_BT  (IFG_BT),
    .DLIM_10 (DEFER_LIMIT_10),
    .DLIM_100(DEFER_LIMIT_100)
  ) u_gap (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .active_i       (state_q == ST_DEFER),
    .tick_i         (tick_i),
    .crs_i          (crs_i),
    .speed_100_i    (speed_100_i),
    .defer_forever_i(defer_forever_i),
    .gap_done_o     (gap_done),
    .limit_hit_o    (limit_hit)
  );

  dfr_backoff #(
    .SLOT_BT(SLOT_BT),
    .BO_CAP (BACKOFF_CAP),
    .ATT_W  (ATT_W)
  ) u_bo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .speed_100_i(speed_100_i),
    .load_i     (bo_load),
    .attempt_i  (att_nx),
    .run_i      (state_q == ST_BACKOFF),
    .tick_i     (tick_i),
    .zero_o     (bo_zero),
    .done_o     (bo_done)
  );

  assign att_nx = att_q + ATT_W'(1);

  always_comb begin
    state_d = state_q;
    att_d   = att_q;
    start_d = 1'b0;
    dab_d   = 1'b0;
    cab_d   = 1'b0;
    bo_load = 1'b0;
    case (state_q)
      ST_IDLE: if (tx_req_i) begin
        state_d = ST_DEFER;
        att_d   = '0;
      end
      ST_DEFER: begin
        if (!tx_req_i) state_d = ST_IDLE;
        else if (limit_hit) begin
          dab_d   = 1'b1;
          state_d = ST_HOLD;
        end else if (gap_done) begin
          start_d = 1'b1;
          state_d = ST_XMIT;
        end
      end
      ST_XMIT: begin
        if (col_i) begin
          att_d = att_nx;
          if (att_nx == ATT_W'(MAX_ATTEMPTS)) begin
            cab_d   = 1'b1;
            state_d = ST_HOLD;
          end else if (no_backoff_i) begin
            state_d = ST_DEFER;
          end else begin
            bo_load = 1'b1;
            state_d = bo_zero ? ST_DEFER : ST_BACKOFF;
          end
        end else if (!tx_req_i) begin
          state_d = ST_IDLE;
        end
      end
      ST_BACKOFF: begin
        if (!tx_req_i)    state_d = ST_IDLE;
        else if (bo_done) state_d = ST_DEFER;
      end
      ST_HOLD: if (!tx_req_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      att_q         <= '0;
      tx_start_o    <= 1'b0;
      defer_abort_o <= 1'b0;
      col_abort_o   <= 1'b0;
    end else begin
      state_q       <= state_d;
      att_q         <= att_d;
      tx_start_o    <= start_d;
      defer_abort_o <= dab_d;
      col_abort_o   <= cab_d;
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o); // R11
  AST_EVENTS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_start_o, defer_abort_o, col_abort_o})); // R11
  AST_START_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> !$past(crs_i)); // R1
  AST_NO_DABORT_FOREVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    defer_forever_i |=> !defer_abort_o); // R4
  AST_CABORT_ON_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_abort_o |-> $past(col_i)); // R8
  AST_CANCEL_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_req_i && state_q != ST_XMIT) |=> !tx_start_o && !defer_abort_o); // R9
  AST_HOLD_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HOLD |=> !tx_start_o); // R10
endmodule

// File: tb/sim_eth_tx_defer_ctrl.sv
module sim_eth_tx_defer_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int P_IFG  = 16;
  localparam int P_SLOT = 32;
  localparam int P_D10  = 300;
  localparam int P_D100 = 80;
  localparam int P_MAX  = 16;
  localparam int P_CAP  = 10;
  localparam int D_MAX  = (P_D10 > P_D100) ? P_D10 : P_D100;

  localparam int M_IDLE = 0, M_DEFER = 1, M_XMIT = 2, M_FREE = 3, M_HOLD = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tx_req_i = 0, crs_i = 0, col_i = 0, speed_100_i = 0, tick_i = 1;
  logic defer_forever_i = 0, no_backoff_i = 0;
  logic tx_start_o, defer_abort_o, col_abort_o;
  int   tick_mode = 0;

  int n_checks = 0, n_fail = 0;
  int n_start = 0, n_dab = 0, n_cab = 0;
  int m_st = M_IDLE, m_att = 0, m_dcnt = 0, m_gap = 0, m_el = 0;
  int m_gl = P_IFG, m_sl = P_SLOT;
  int e_start = 0, e_dab = 0, e_cab = 0, prev_start = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_tx_defer_ctrl #(
    .IFG_BT(P_IFG), .SLOT_BT(P_SLOT), .DEFER_LIMIT_10(P_D10),
    .DEFER_LIMIT_100(P_D100), .MAX_ATTEMPTS(P_MAX), .BACKOFF_CAP(P_CAP)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tx_req_i(tx_req_i), .crs_i(crs_i),
    .col_i(col_i), .speed_100_i(speed_100_i), .tick_i(tick_i),
    .defer_forever_i(defer_forever_i), .no_backoff_i(no_backoff_i),
    .tx_start_o(tx_start_o), .defer_abort_o(defer_abort_o), .col_abort_o(col_abort_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) tick_i <= (tick_mode == 0) ? 1'b1 : ~tick_i;

  // behavioural reference: one step per rising edge
  task automatic model_step();
    int dlim;
    e_start = 0; e_dab = 0; e_cab = 0;
    m_gl = speed_100_i ? P_IFG / 4 : P_IFG;
    m_sl = speed_100_i ? P_SLOT / 4 : P_SLOT;
    dlim = speed_100_i ? P_D100 : P_D10;
    if (!rst_ni) begin
      m_st = M_IDLE; m_att = 0; m_dcnt = 0; m_gap = 0;
      return;
    end
    case (m_st)
      M_IDLE: if (tx_req_i) begin m_st = M_DEFER; m_att = 0; m_dcnt = 0; m_gap = 0; end
      M_DEFER: begin
        if (!tx_req_i) m_st = M_IDLE;
        else if (crs_i) begin
          m_gap = 0;
          if (tick_i) begin
            if (!defer_forever_i && m_dcnt + 1 >= dlim) begin e_dab = 1; m_st = M_HOLD; end
            else if (m_dcnt < D_MAX) m_dcnt++;
          end
        end else if (tick_i) begin
          if (m_gap + 1 >= m_gl) begin e_start = 1; m_st = M_XMIT; end
          else m_gap++;
        end
      end
      M_XMIT: begin
        if (col_i) begin
          m_att++;
          if (m_att == P_MAX) begin e_cab = 1; m_st = M_HOLD; end
          else if (no_backoff_i) begin m_st = M_DEFER; m_gap = 0; m_dcnt = 0; end
          else begin m_st = M_FREE; m_el = 0; end
        end else if (!tx_req_i) m_st = M_IDLE;
      end
      M_FREE: begin
        if (!tx_req_i) m_st = M_IDLE;
        else m_el++;
      end
      M_HOLD: if (!tx_req_i) m_st = M_IDLE;
      default: m_st = M_IDLE;
    endcase
  endtask

  task automatic compare();
    int k, d;
    if (!rst_ni) return;
    chk($countones({tx_start_o, defer_abort_o, col_abort_o}) <= 1, "R11", "events overlap",
        $countones({tx_start_o, defer_abort_o, col_abort_o}), 1);
    chk(!(prev_start && tx_start_o), "R11", "start wider than one cycle", 2, 1);
    if (m_st == M_FREE) begin
      k = (m_att < P_CAP) ? m_att : P_CAP;
      chk(!defer_abort_o && !col_abort_o, "R7", "abort during backoff", 1, 0);
      if (tx_start_o) begin
        d = m_el - m_gl;
        chk(d >= 0 && (d % m_sl) == 0 && (d / m_sl) < (1 << k), "R7", "backoff delay", m_el, m_gl);
        m_st = M_XMIT;
      end else if (m_el > m_gl + ((1 << k) - 1) * m_sl) begin
        chk(0, "R7", "backoff overrun", m_el, m_gl + ((1 << k) - 1) * m_sl);
        m_st = M_XMIT;
      end
    end else begin
      chk(int'(tx_start_o) == e_start, "R1", "tx_start_o", int'(tx_start_o), e_start);
      chk(int'(defer_abort_o) == e_dab, speed_100_i ? "R3" : "R2", "defer_abort_o",
          int'(defer_abort_o), e_dab);
      chk(int'(col_abort_o) == e_cab, "R8", "col_abort_o", int'(col_abort_o), e_cab);
    end
    if (tx_start_o)    n_start++;
    if (defer_abort_o) n_dab++;
    if (col_abort_o)   n_cab++;
    prev_start = int'(tx_start_o);
  endtask

  always begin
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_start(input int lim, input string req);
    int s0 = n_start;
    int i = 0;
    while (n_start == s0 && i < lim) begin
      @(negedge clk);
      i++;
    end
    chk(n_start != s0, req, "start never came", 0, 1);
    cyc(1);
  endtask

  task automatic pulse_col();
    col_i = 1'b1;
    cyc(1);
    col_i = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired");
    n_fail++;
    summary();
    $finish;
  end

  initial begin
    int s0, d0, c0;
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    chk(!tx_start_o && !defer_abort_o && !col_abort_o, "R12", "outputs after reset",
        int'({tx_start_o, defer_abort_o, col_abort_o}), 0);

    // R1: plain start, gap restart, 100M gap
    s0 = n_start;
    tx_req_i = 1; wait_start(100, "R1"); cyc(4); tx_req_i = 0; cyc(3);
    chk(n_start - s0 == 1, "R1", "single start", n_start - s0, 1);
    crs_i = 1; tx_req_i = 1; cyc(5); crs_i = 0; cyc(10); crs_i = 1; cyc(2); crs_i = 0;
    wait_start(100, "R1"); tx_req_i = 0; cyc(2);
    speed_100_i = 1; tx_req_i = 1; wait_start(50, "R1"); tx_req_i = 0; cyc(2); speed_100_i = 0;

    // R2 then R10
    s0 = n_start; d0 = n_dab;
    crs_i = 1; tx_req_i = 1; cyc(320);
    chk(n_dab - d0 == 1, "R2", "10M deferral abort", n_dab - d0, 1);
    crs_i = 0; cyc(40);
    chk(n_start == s0, "R10", "no start while request held after abort", n_start - s0, 0);
    tx_req_i = 0; cyc(2); tx_req_i = 1; wait_start(100, "R10"); tx_req_i = 0; cyc(2);

    // R3: 100M, tick every other cycle
    d0 = n_dab;
    speed_100_i = 1; tick_mode = 1; crs_i = 1; tx_req_i = 1; cyc(200);
    chk(n_dab - d0 == 1, "R3", "100M deferral abort", n_dab - d0, 1);
    tx_req_i = 0; crs_i = 0; cyc(2); tick_mode = 0; speed_100_i = 0; cyc(2);

    // R4
    d0 = n_dab; s0 = n_start;
    defer_forever_i = 1; crs_i = 1; tx_req_i = 1; cyc(500);
    chk(n_dab == d0, "R4", "no abort when deferring forever", n_dab - d0, 0);
    crs_i = 0; wait_start(100, "R4"); tx_req_i = 0; cyc(2); defer_forever_i = 0;

    // R5: accumulation, then clear at start
    d0 = n_dab;
    crs_i = 1; tx_req_i = 1; cyc(200); crs_i = 0; cyc(5); crs_i = 1; cyc(150);
    chk(n_dab - d0 == 1, "R5", "accumulated deferral abort", n_dab - d0, 1);
    tx_req_i = 0; crs_i = 0; cyc(2);
    d0 = n_dab;
    crs_i = 1; tx_req_i = 1; cyc(250); crs_i = 0; wait_start(100, "R5");
    no_backoff_i = 1; crs_i = 1; pulse_col(); cyc(250); crs_i = 0; wait_start(100, "R5");
    chk(n_dab == d0, "R5", "count cleared at start", n_dab - d0, 0);
    tx_req_i = 0; cyc(2);

    // R6
    s0 = n_start;
    tx_req_i = 1; wait_start(100, "R6"); pulse_col(); wait_start(100, "R6");
    chk(n_start - s0 == 2, "R6", "immediate retry", n_start - s0, 2);
    tx_req_i = 0; cyc(2); no_backoff_i = 0;

    // R7: 10M backoff
    s0 = n_start;
    tx_req_i = 1; wait_start(100, "R7");
    for (int i = 0; i < 4; i++) begin pulse_col(); wait_start(5000, "R7"); end
    chk(n_start - s0 == 5, "R7", "retries after backoff", n_start - s0, 5);
    tx_req_i = 0; cyc(2);

    // R8: 16 collisions at 100M
    speed_100_i = 1; c0 = n_cab;
    tx_req_i = 1; wait_start(100, "R8");
    for (int i = 0; i < 16; i++) begin
      pulse_col();
      if (i < 15) wait_start(20000, "R8");
    end
    s0 = n_start; cyc(60);
    chk(n_cab - c0 == 1, "R8", "excessive collision abort", n_cab - c0, 1);
    chk(n_start == s0, "R8", "no start after give-up", n_start - s0, 0);
    tx_req_i = 0; cyc(2); speed_100_i = 0;

    // R9: cancel paths
    s0 = n_start; d0 = n_dab;
    crs_i = 1; tx_req_i = 1; cyc(20); tx_req_i = 0; cyc(5); crs_i = 0; cyc(30);
    chk(n_start == s0 && n_dab == d0, "R9", "cancel while deferring", n_start - s0, 0);
    tx_req_i = 1; wait_start(100, "R9");
    s0 = n_start;
    col_i = 1; tx_req_i = 0; cyc(1); col_i = 0; cyc(600);
    chk(n_start == s0, "R9", "cancel after collision", n_start - s0, 0);

    // R12: reset clears collision count
    no_backoff_i = 1; speed_100_i = 1; c0 = n_cab;
    tx_req_i = 1; wait_start(100, "R12");
    for (int i = 0; i < 15; i++) begin pulse_col(); wait_start(100, "R12"); end
    rst_ni = 0; cyc(2);
    chk(!tx_start_o && !defer_abort_o && !col_abort_o, "R12", "outputs in reset",
        int'({tx_start_o, defer_abort_o, col_abort_o}), 0);
    rst_ni = 1; wait_start(100, "R12");
    for (int i = 0; i < 15; i++) begin pulse_col(); wait_start(100, "R12"); end
    chk(n_cab == c0, "R12", "count restarted after reset", n_cab - c0, 0);
    pulse_col(); cyc(5);
    chk(n_cab - c0 == 1, "R12", "16th collision after reset", n_cab - c0, 1);
    tx_req_i = 0; cyc(5);

    summary();
    $finish;
  end
endmodule